// File: doc/BRIEF.md
# Fire Code Burst-Trapping Decoder

This block receives a 105-bit codeword one bit per accepted cycle and repairs any single error burst that spans at most four adjacent positions, the burst being allowed to wrap from the top of the word back to its bottom. The code has a degree-11 generator, the product of (X^7 + 1) and the primitive polynomial X^4 + X + 1. Its length is 105, the least common multiple of 7 and 15, and it carries 94 information bits.

While the bits arrive they are stored in a shift buffer and divided by the generator in an 11-stage syndrome register. Each bit enters that register at its low end. The decoder then rotates the syndrome, which multiplies it by X modulo the generator. It stops as soon as the seven upper stages are clear and the four lower stages are not. At that moment the lower stages hold the burst pattern, and the number of rotations made tells where the burst sits, so the whole pattern is folded into the buffer in one cycle.

A zero syndrome releases the word untouched. A syndrome that never traps within 105 rotations is flagged as uncorrectable, and the buffered word is released as received. A caller streams in one word and waits for the `done` pulse before streaming the next word.

Top module: `fire_trap_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `done`, `corrected`, `uncorrectable` and `word_out` to zero.
- R2: A bit is taken only on a rising edge with `in_valid` high while the block is receiving. The first bit taken is the coefficient of X^104 and ends in `word_out[104]`, and the 105th bit taken ends in `word_out[0]`. Two `done` pulses are therefore at least 105 cycles apart.
- R3: A received word whose syndrome is zero is released unchanged, with `corrected` = 0 and `uncorrectable` = 0.
- R4: A codeword hit by any burst of length 1 to 4, starting at any of the 105 positions (including bursts that wrap from bit 104 to bit 0), is released as the original codeword with `corrected` = 1 and `uncorrectable` = 0.
- R5: A received word that lies within no burst of length 4 or less of a codeword is released bit-for-bit as received, with `uncorrectable` = 1 and `corrected` = 0.
- R6: `done` is high for exactly one cycle. It rises between 1 and 105 cycles after the edge that took the last bit, and exactly 1 cycle after it when the syndrome is zero.
- R7: `in_valid` and `in_bit` have no effect from the edge that takes a word's last bit until the cycle after `done`.
- R8: `corrected` and `uncorrectable` are never high together. They change only at the edge that raises `done`, and they hold until the next word's `done`.
- R9: The generator is X^11 + X^8 + X^7 + X^4 + X + 1. Every word built systematically from it (94 information bits in positions 104..11, remainder in 10..0) decodes as error-free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_bit` carries a received bit this cycle |
| in_bit | input | 1 | Received bit, highest-order coefficient first |
| done | output | 1 | One-cycle pulse: the decoded word and verdict are ready |
| word_out | output | 105 | Buffered word; bit i is the coefficient of X^i |
| corrected | output | 1 | The last word had one burst repaired |
| uncorrectable | output | 1 | The last word could not be repaired |

## Verification
On every cycle, the assertions check the following:
- The two verdict flags are exclusive.
- `done` lasts a single cycle, and at least a word's worth of cycles separate two `done` pulses.
- The flags move only together with `done`.
- The buffer is left untouched by a clean or failed verdict.
- A repair changes between one and four bits.

Only the bench's scenarios can show that the repaired bits are the right ones. To do so it injects bursts at every start position, including ones that wrap, and compares the result against the transmitted codeword. It also judges arbitrary heavier errors against its own table of all 840 burst syndromes, checks that the timing depends on how far the burst lies from the trap point, and checks that stray input during decoding is ignored.

// File: rtl/firedec_pkg.sv
// Package: shared constants, helper functions and the controller state
// type for the Fire-code decoder. Assumes burst length and primitive
// degree are small enough that the generator fits in 64 bits.
package firedec_pkg;

    // Greatest common divisor, evaluated at elaboration time.
    function automatic int gcd_f(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Least common multiple; gives the code length from the two periods.
    function automatic int lcm_f(input int a, input int b);
        return (a / gcd_f(a, b)) * b;
    endfunction

    // Generator = (X^rep + 1) * prim(X) over GF(2).
    function automatic logic [63:0] gen_poly_f(input int rep, input logic [31:0] prim,
                                               input int pdeg);
        logic [63:0] g;
        g = '0;
        for (int i = 0; i <= pdeg; i++) begin
            if (prim[i]) begin
                g[i]       = ~g[i];
                g[i + rep] = ~g[i + rep];
            end
        end
        return g;
    endfunction

    // Controller phases: taking bits, rotating the syndrome, releasing.
    typedef enum logic [1:0] {
        ST_RECV   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_OUT    = 2'd2
    } dec_state_t;

endpackage

// File: rtl/fire_syndrome_reg.sv
// Syndrome register: an NPAR-stage divider by the generator polynomial.
// In load mode a received bit enters at stage 0, so after all bits the
// register holds r(X) mod g(X). In rotate mode it multiplies the content
// by X modulo g(X). Assumes load and rotate are never requested together
// (load takes priority).
module fire_syndrome_reg #(
    parameter int              NPAR = 11,
    parameter logic [NPAR:0]   GEN  = 12'h993
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            load_en,
    input  logic            load_bit,
    input  logic            rot_en,
    output logic [NPAR-1:0] syn
);

    localparam logic [NPAR-1:0] FB_TAPS = GEN[NPAR-1:0];

    logic [NPAR-1:0] fb_mask;

    // Feedback term: generator taps when the top stage overflows.
    always_comb begin
        fb_mask = syn[NPAR-1] ? FB_TAPS : '0;
    end

    // Division step on load, multiply-by-X step on rotate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn <= '0;
        end else if (clear) begin
            syn <= '0;
        end else if (load_en) begin
            syn <= {syn[NPAR-2:0], load_bit} ^ fb_mask;
        end else if (rot_en) begin
            syn <= {syn[NPAR-2:0], 1'b0} ^ fb_mask;
        end
    end

endmodule

// File: rtl/fire_trap_detect.sv
// Trap detector and correction-mask builder. A trap is an empty upper
// part (stages BURST..NPAR-1) with a nonzero lower part. The correction
// mask is the lower part rotated right by the rotation count, which
// places pattern bit k at word position (k - count) mod NLEN.
// Assumes shift_cnt < NLEN.
module fire_trap_detect #(
    parameter int NPAR  = 11,
    parameter int BURST = 4,
    parameter int NLEN  = 105,
    parameter int CW    = 7
) (
    input  logic [NPAR-1:0] syn,
    input  logic [CW-1:0]   shift_cnt,
    output logic            syn_zero,
    output logic            syn_trapped,
    output logic [NLEN-1:0] fix_mask
);

    logic [NLEN-1:0] pat_w;

    // Classify the syndrome.
    always_comb begin
        syn_zero    = (syn == '0);
        syn_trapped = (syn[NPAR-1:BURST] == '0) && (syn[BURST-1:0] != '0);
    end

    // Rotate the trapped pattern back to its place in the word.
    always_comb begin
        pat_w    = NLEN'(syn[BURST-1:0]);
        fix_mask = (pat_w >> shift_cnt) | (pat_w << (NLEN - int'(shift_cnt)));
    end

endmodule

// File: rtl/fire_dec_ctrl.sv
// Decoder sequencer. It counts NLEN accepted bits, then up to NLEN
// syndrome checks (count 0..NLEN-1), then spends one cycle in the
// release phase. The verdict strobes fire in the last search cycle.
// Assumes syn_zero and syn_trapped reflect the current syndrome.
module fire_dec_ctrl
    import firedec_pkg::*;
#(
    parameter int NLEN = 105,
    parameter int CW   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          syn_zero,
    input  logic          syn_trapped,
    output logic          take_bit,
    output logic          rot_en,
    output logic          syn_clear,
    output logic          clean_en,
    output logic          fix_en,
    output logic          fail_en,
    output logic          done,
    output logic [CW-1:0] shift_cnt
);

    localparam logic [CW-1:0] LAST = CW'(NLEN - 1);

    dec_state_t   state;
    logic [CW-1:0] cnt;
    logic          in_search;
    logic          at_last;

    assign shift_cnt = cnt;

    // Per-cycle strobes decoded from the phase and the syndrome class.
    always_comb begin
        in_search = (state == ST_SEARCH);
        at_last   = (cnt == LAST);
        take_bit  = (state == ST_RECV) && in_valid;
        clean_en  = in_search && syn_zero;
        fix_en    = in_search && syn_trapped;
        fail_en   = in_search && !syn_zero && !syn_trapped && at_last;
        rot_en    = in_search && !syn_zero && !syn_trapped && !at_last;
        syn_clear = (state == ST_OUT);
        done      = (state == ST_OUT);
    end

    // Phase and bit/rotation counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RECV;
            cnt   <= '0;
        end else begin
            case (state)
                ST_RECV: begin
                    if (in_valid) begin
                        if (at_last) begin
                            cnt   <= '0;
                            state <= ST_SEARCH;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (syn_zero || syn_trapped || at_last) begin
                        cnt   <= '0;
                        state <= ST_OUT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_OUT:  state <= ST_RECV;
                default: state <= ST_RECV;
            endcase
        end
    end

endmodule

// File: rtl/fire_trap_decoder.sv
// Top: serial Fire-code decoder with whole-burst error trapping.
// Bits arrive highest-order coefficient first. The code is fixed by the
// burst length and a primitive polynomial. Assumes the caller waits for
// `done` before streaming the next word.
module fire_trap_decoder
    import firedec_pkg::*;
#(
    parameter  int                BURST_LEN = 4,
    parameter  int                PRIM_DEG  = 4,
    parameter  logic [PRIM_DEG:0] PRIM_POLY = 5'b10011,
    localparam int                REP_LEN   = 2 * BURST_LEN - 1,
    localparam int                NPAR      = REP_LEN + PRIM_DEG,
    localparam int                NLEN      = lcm_f(REP_LEN, (1 << PRIM_DEG) - 1),
    localparam int                CW        = $clog2(NLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_bit,
    output logic            done,
    output logic [NLEN-1:0] word_out,
    output logic            corrected,
    output logic            uncorrectable
);

    localparam logic [NPAR:0] GEN = (NPAR + 1)'(gen_poly_f(REP_LEN, 32'(PRIM_POLY), PRIM_DEG));

    logic            take_bit;
    logic            rot_en;
    logic            syn_clear;
    logic            clean_en;
    logic            fix_en;
    logic            fail_en;
    logic [CW-1:0]   shift_cnt;
    logic [NPAR-1:0] syn;
    logic            syn_zero;
    logic            syn_trapped;
    logic [NLEN-1:0] fix_mask;

    fire_dec_ctrl #(
        .NLEN (NLEN),
        .CW   (CW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .syn_zero    (syn_zero),
        .syn_trapped (syn_trapped),
        .take_bit    (take_bit),
        .rot_en      (rot_en),
        .syn_clear   (syn_clear),
        .clean_en    (clean_en),
        .fix_en      (fix_en),
        .fail_en     (fail_en),
        .done        (done),
        .shift_cnt   (shift_cnt)
    );

    fire_syndrome_reg #(
        .NPAR (NPAR),
        .GEN  (GEN)
    ) u_syn (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (syn_clear),
        .load_en  (take_bit),
        .load_bit (in_bit),
        .rot_en   (rot_en),
        .syn      (syn)
    );

    fire_trap_detect #(
        .NPAR  (NPAR),
        .BURST (BURST_LEN),
        .NLEN  (NLEN),
        .CW    (CW)
    ) u_trap (
        .syn         (syn),
        .shift_cnt   (shift_cnt),
        .syn_zero    (syn_zero),
        .syn_trapped (syn_trapped),
        .fix_mask    (fix_mask)
    );

    // Word buffer: shift in received bits, fold in the burst on a trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
        end else if (take_bit) begin
            word_out <= {word_out[NLEN-2:0], in_bit};
        end else if (fix_en) begin
            word_out <= word_out ^ fix_mask;
        end
    end

    // Verdict flags, updated once per word at the end of the search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corrected     <= 1'b0;
            uncorrectable <= 1'b0;
        end else if (clean_en) begin
            corrected     <= 1'b0;
            uncorrectable <= 1'b0;
        end else if (fix_en) begin
            corrected     <= 1'b1;
            uncorrectable <= 1'b0;
        end else if (fail_en) begin
            corrected     <= 1'b0;
            uncorrectable <= 1'b1;
        end
    end

endmodule

// File: rtl/fire_trap_decoder_chk.sv
// Checker for the decoder's port-level timing and verdict rules.
// A gap counter measures cycles since reset or the last done pulse.
module fire_trap_decoder_chk #(
    parameter int NLEN      = 105,
    parameter int BURST_LEN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            done,
    input logic            corrected,
    input logic            uncorrectable,
    input logic [NLEN-1:0] word_out
);

    localparam int GW = $clog2(NLEN + 2) + 1;

    logic [GW-1:0] gap;

    // Saturating count of cycles since the last done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (done) begin
            gap <= '0;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(corrected && uncorrectable));

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({corrected, uncorrectable}) |-> done);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    word_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (gap >= GW'(NLEN)));

    // R3 R5
    untouched_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !corrected) |-> $stable(word_out));

    // R4
    burst_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && corrected) |-> (($countones(word_out ^ $past(word_out)) >= 1) &&
                                 ($countones(word_out ^ $past(word_out)) <= BURST_LEN)));

endmodule

bind fire_trap_decoder fire_trap_decoder_chk #(
    .NLEN      (NLEN),
    .BURST_LEN (BURST_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done          (done),
    .corrected     (corrected),
    .uncorrectable (uncorrectable),
    .word_out      (word_out)
);

// File: tb/fire_trap_decoder_bench.sv
// Scoreboard bench: the driver queues expected results and streams words,
// the monitor pops and compares on every done pulse.
module fire_trap_decoder_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 105;
    localparam int          K          = 94;
    localparam logic [11:0] GPOLY      = 12'h993;  // X^11+X^8+X^7+X^4+X+1

    logic         clk;
    logic         rst_n;
    logic         in_valid;
    logic         in_bit;
    logic         done;
    logic [N-1:0] word_out;
    logic         corrected;
    logic         uncorrectable;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int mark   = 0;
    int sent   = 0;
    int seen   = 0;
    bit finished = 0;

    logic [N-1:0] q_word[$];
    logic [1:0]   q_flag[$];
    string        q_tag[$];
    logic [10:0]  tbl[N*8];

    fire_trap_decoder u_fire_trap_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_bit        (in_bit),
        .done          (done),
        .word_out      (word_out),
        .corrected     (corrected),
        .uncorrectable (uncorrectable)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Remainder of v(X) divided by the generator.
    function automatic logic [10:0] rem_f(input logic [N-1:0] v);
        logic [N-1:0] t;
        t = v;
        for (int i = N - 1; i >= 11; i--)
            if (t[i]) t[i-11 +: 12] = t[i-11 +: 12] ^ GPOLY;
        return t[10:0];
    endfunction

    function automatic logic [N-1:0] encode_f(input logic [K-1:0] info);
        logic [N-1:0] t;
        t = {info, 11'b0};
        return t | N'(rem_f(t));
    endfunction

    function automatic logic [N-1:0] burst_f(input int pos, input logic [3:0] pat);
        logic [N-1:0] v;
        v = '0;
        for (int k = 0; k < 4; k++)
            if (pat[k]) v[(pos + k) % N] = 1'b1;
        return v;
    endfunction

    function automatic logic [K-1:0] rand_info();
        return K'({$urandom(), $urandom(), $urandom()});
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: queue the expectation, stream the word, poke stray input
    // during decoding (R7), then wait for the monitor.
    task automatic send_word(input logic [N-1:0] rx, input logic [N-1:0] exp_w,
                             input logic [1:0] exp_f, input string tag, input bit gaps);
        q_word.push_back(exp_w);
        q_flag.push_back(exp_f);
        q_tag.push_back(tag);
        sent++;
        for (int i = N - 1; i >= 0; i--) begin
            @(negedge clk);
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 1'b0;
                in_bit   = ~rx[i];
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_bit   = rx[i];
        end
        @(negedge clk);
        mark     = cyc;
        in_valid = 1'b1;
        in_bit   = 1'($urandom);
        @(negedge clk);
        in_bit   = ~in_bit;
        @(negedge clk);
        in_valid = 1'b0;
        while (seen != sent) @(negedge clk);
    endtask

    // Monitor: compare each released word against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done && !finished) begin
            logic [N-1:0] ew;
            logic [1:0]   ef;
            string        tg;
            int           lat;
            if (q_word.size() == 0) begin
                check(1'b0, "R6", "unexpected done", N'(1), N'(0));
            end else begin
                ew  = q_word.pop_front();
                ef  = q_flag.pop_front();
                tg  = q_tag.pop_front();
                lat = cyc - mark;
                check(word_out == ew, tg, "word", word_out, ew);
                check({corrected, uncorrectable} == ef, tg, "flags {corr,unc}",
                      N'({corrected, uncorrectable}), N'(ef));
                check(lat >= 1 && lat <= N, "R6", "latency", N'(lat), N'(N));
                if (ef == 2'b00)
                    check(lat == 1, "R6", "clean latency", N'(lat), N'(1));
            end
            seen++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] cw;
        logic [N-1:0] rx;
        logic [N-1:0] err;
        logic [3:0]   pat;
        logic [10:0]  s;
        int           len;
        int           hit;

        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_bit   = 1'b1;
        for (int p = 0; p < N; p++)
            for (int j = 0; j < 8; j++)
                tbl[p*8 + j] = rem_f(burst_f(p, 4'(2*j + 1)));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(word_out == '0, "R1", "word at reset", word_out, '0);
        check(!done && !corrected && !uncorrectable, "R1", "flags at reset",
              N'({done, corrected, uncorrectable}), '0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);

        // R9 / R3: clean codewords, including all-zero and with idle gaps
        send_word('0, '0, 2'b00, "R3", 1'b0);
        for (int w = 0; w < 3; w++) begin
            cw = encode_f(rand_info());
            send_word(cw, cw, 2'b00, "R9", w == 1);
        end
        cw = encode_f({K{1'b1}});
        send_word(cw, cw, 2'b00, "R2", 1'b1);

        // R4: a burst at every start position (wrapping at the top end)
        for (int p = 0; p < N; p++) begin
            cw  = encode_f(rand_info());
            len = 1 + int'($urandom % 4);
            pat = 4'($urandom) & 4'((1 << len) - 1);
            pat[0] = 1'b1;
            pat[len-1] = 1'b1;
            send_word(cw ^ burst_f(p, pat), cw, 2'b10, "R4", (p % 17) == 0);
        end
        // R4: explicit wrapping bursts
        cw = encode_f(rand_info());
        send_word(cw ^ burst_f(104, 4'b1111), cw, 2'b10, "R4", 1'b0);
        send_word(cw ^ burst_f(103, 4'b1001), cw, 2'b10, "R4", 1'b0);
        send_word(cw ^ burst_f(102, 4'b1011), cw, 2'b10, "R4", 1'b0);

        // R5: scattered errors judged by the full burst-syndrome table
        for (int w = 0; w < 8; w++) begin
            cw  = encode_f(rand_info());
            err = burst_f(w * 3, 4'b0001) | burst_f(w * 3 + 40 + w, 4'b0001) |
                  burst_f(w * 5 + 77, 4'(w & 1));
            rx  = cw ^ err;
            s   = rem_f(rx);
            hit = -1;
            for (int i = 0; i < N * 8; i++)
                if (hit < 0 && tbl[i] == s) hit = i;
            if (hit < 0)
                send_word(rx, rx, 2'b01, "R5", 1'b0);
            else
                send_word(rx, rx ^ burst_f(hit / 8, 4'(2*(hit % 8) + 1)), 2'b10, "R5", 1'b0);
        end

        repeat (5) @(negedge clk);
        // R7: stray input during decoding left nothing queued
        check(q_word.size() == 0, "R7", "pending results", N'(q_word.size()), '0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule